// File: doc/BRIEF.md
# Digital PLL Bit-Clock Recovery

This block takes an already-sliced, asynchronous serial data line and rebuilds from it a bit clock and a retimed copy of the data. A 24-bit phase accumulator advances by a programmed nominal increment on every tick of a divided-down sample clock. One full turn of the accumulator is one bit period. At each data transition the accumulator value, read as a signed number, is the phase error. A proportional path and an integrating path turn that error into a frequency correction. The correction is scaled by a loop gain, limited to a fraction of the nominal increment and then added to the increment.

Software-facing controls arrive as plain input ports: the nominal increment, the three gain codes, the pre-divider code, the clamp code, the quiet-bit limit, a free-run switch, the sample-point choice and a manual reset path. The recovered clock rises at the start of every bit. The retimed data changes only on that rising edge. A lock flag shows that the loop has caught an edge and is tracking.

Top module: `dpll_cdr`

## Requirements
- R1: After reset, rec_clk is 1, rec_data is 0 and locked is 0.
- R2: With free_run high the correction is zero, no data edge moves the phase, locked is held at 0, and rec_clk has a period of 2^24/nom_inc ticks, which is 16 sample-clock cycles for nom_inc = 0x200000 with div_code 0.
- R3: One tick occurs every N sample-clock cycles. N is 2, 4, 8, 16, 20, 32, 40 or 48 for div_code 0 to 7, so no two consecutive cycles carry a tick.
- R4: While acquiring, the first data edge zeroes the accumulator, so the bit start lines up with that edge. It also clears the correction and the integrator and raises locked on the next cycle. locked rises only after a data edge.
- R5: Each later edge takes the signed accumulator value e. It adds e to the integrator I and forms g = (e >>> kp_code) + (I >>> ki_code). g is then scaled by 2^(kg_code-3), as a right shift for codes 0 to 2 and a left shift for codes 4 to 7. The held correction becomes -g, so an edge that comes late slows the clock.
- R6: The held correction is limited to ±(nom_inc >> (3 + clamp_code)), which is 1/8, 1/16, 1/32 or 1/64 of the nominal increment. This bounds the shortest bit period the loop can reach.
- R7: quiet_code 0 disables the quiet check. Codes 1, 2 and 3 mean 2, 4 and 8 bit periods. When that many accumulator wraps pass with no data edge, the loop clears its correction, drops locked and waits to re-acquire on the next edge.
- R8: With mid_sample at 0, the retimed data is the synchronised input at the bit-start wrap. With mid_sample at 1, it is the value captured when the accumulator crosses half a turn.
- R9: rec_data changes only on a tick that wraps the accumulator, where rec_clk rises, or on a manual reset.
- R10: With man_rst_en high, a man_rst pulse returns the whole loop to its reset state (locked 0, rec_data 0). With man_rst_en low, man_rst has no effect.
- R11: din passes through two flip-flops before any use. Edges are detected on the synchronised value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 1 | Sliced serial data, asynchronous |
| nom_inc | input | 24 | Nominal accumulator increment per tick |
| kp_code | input | 3 | Proportional divide, 2^code |
| ki_code | input | 3 | Integrator divide, 2^code |
| kg_code | input | 3 | Loop gain, 2^(code-3) |
| div_code | input | 3 | Sample-clock pre-divider select |
| clamp_code | input | 2 | Correction limit select |
| quiet_code | input | 2 | Quiet-bit re-acquire limit |
| free_run | input | 1 | Disable phase alignment |
| mid_sample | input | 1 | 1: sample mid-bit, 0: sample at bit start |
| man_rst_en | input | 1 | Enable the manual reset input |
| man_rst | input | 1 | Manual loop reset |
| rec_clk | output | 1 | Recovered bit clock |
| rec_data | output | 1 | Retimed data |
| locked | output | 1 | Loop tracking flag |

## Verification
The bench places data edges a known number of cycles either side of the half-bit point and the bit-start point. A design that swapped or misplaced the sample point returns the wrong bit. A fast data stream shows whether the clamp bounds the bit period: a design that ignored the clamp or shifted it by the wrong amount gives a 64-bit span outside the window expected for each clamp code. The quiet-bit test checks locked just before and just after the 2-bit and 8-bit limits, which catches an off-by-one or a swapped code. It then confirms that the next edge re-locks. Manual reset is pulsed with the enable both low and high. A design that ignored the enable, or cleared too little, leaves the wrong locked or rec_data value.

// File: rtl/dpll_cdr.sv
module dpll_cdr #(
  parameter int W    = 24,
  parameter int INTW = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         din,
  input  logic [W-1:0] nom_inc,
  input  logic [2:0]   kp_code,
  input  logic [2:0]   ki_code,
  input  logic [2:0]   kg_code,
  input  logic [2:0]   div_code,
  input  logic [1:0]   clamp_code,
  input  logic [1:0]   quiet_code,
  input  logic         free_run,
  input  logic         mid_sample,
  input  logic         man_rst_en,
  input  logic         man_rst,
  output logic         rec_clk,
  output logic         rec_data,
  output logic         locked
);
  localparam int EW = INTW + 8;

  logic s_meta, s_data, s_prev;
  logic [5:0] div_cnt, ratio;
  logic [W-1:0] acc;
  logic signed [W+1:0] corr;
  logic signed [INTW-1:0] integ, integ_nx;
  logic [3:0] qcnt, qlim;
  logic acq, mid_q;

  always_comb begin
    case (div_code)
      3'd0: ratio = 6'd2;
      3'd1: ratio = 6'd4;
      3'd2: ratio = 6'd8;
      3'd3: ratio = 6'd16;
      3'd4: ratio = 6'd20;
      3'd5: ratio = 6'd32;
      3'd6: ratio = 6'd40;
      default: ratio = 6'd48;
    endcase
  end

  wire clr  = man_rst_en & man_rst;
  wire tick = (div_cnt >= ratio - 6'd1);
  wire edge_seen = s_data ^ s_prev;

  wire [W+1:0] inc_w = {2'b00, nom_inc} + $unsigned(corr);
  wire [W:0]   sum   = {1'b0, acc} + {1'b0, inc_w[W-1:0]};
  wire wrap = tick & sum[W];
  wire mid_cross = tick & ~acc[W-1] & sum[W-1] & ~sum[W];

  assign qlim = 4'd1 << quiet_code;
  wire quiet_hit = (quiet_code != 2'd0) & ~acq & (qcnt >= qlim);

  logic signed [EW-1:0] err_x, p_t, i_t, pi_t, g_t, lim_t, raw_t, cl_t;
  always_comb begin
    integ_nx = integ + INTW'($signed(acc));
    err_x = EW'($signed(acc));
    p_t   = err_x >>> kp_code;
    i_t   = EW'(integ_nx) >>> ki_code;
    pi_t  = p_t + i_t;
    g_t   = (kg_code < 3'd3) ? (pi_t >>> (3'd3 - kg_code)) : (pi_t <<< (kg_code - 3'd3));
    lim_t = $signed({{(EW-W){1'b0}}, nom_inc >> (3'd3 + {1'b0, clamp_code})});
    raw_t = -g_t;
    if (raw_t > lim_t)       cl_t = lim_t;
    else if (raw_t < -lim_t) cl_t = -lim_t;
    else                     cl_t = raw_t;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {s_meta, s_data, s_prev} <= 3'b000;
      div_cnt <= '0; acc <= '0; corr <= '0; integ <= '0;
      qcnt <= '0; acq <= 1'b1; mid_q <= 1'b0; rec_data <= 1'b0; locked <= 1'b0;
    end else if (clr) begin
      {s_meta, s_data, s_prev} <= 3'b000;
      div_cnt <= '0; acc <= '0; corr <= '0; integ <= '0;
      qcnt <= '0; acq <= 1'b1; mid_q <= 1'b0; rec_data <= 1'b0; locked <= 1'b0;
    end else begin
      s_meta <= din;
      s_data <= s_meta;
      s_prev <= s_data;
      div_cnt <= tick ? '0 : div_cnt + 6'd1;
      if (tick) acc <= sum[W-1:0];
      if (mid_cross) mid_q <= s_data;
      if (wrap) begin
        if (qcnt != 4'hf) qcnt <= qcnt + 4'd1;
        rec_data <= mid_sample ? mid_q : s_data;
      end
      if (free_run) begin
        corr <= '0; integ <= '0; acq <= 1'b1; locked <= 1'b0;
      end else if (edge_seen) begin
        qcnt <= '0;
        if (acq) begin
          acc <= '0; corr <= '0; integ <= '0; acq <= 1'b0; locked <= 1'b1;
        end else begin
          integ <= integ_nx;
          corr  <= $signed(cl_t[W+1:0]);
        end
      end else if (quiet_hit) begin
        corr <= '0; integ <= '0; acq <= 1'b1; locked <= 1'b0;
      end
    end
  end

  assign rec_clk = ~acc[W-1];

  // R3
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick);
  // R2
  free_run_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n) free_run |=> !locked);
  // R10
  man_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) clr |=> (!locked && !rec_data));
  // R9
  data_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rec_data) |-> ($past(wrap) || $past(clr)));
  // R4
  lock_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(edge_seen));
endmodule

// File: tb/dpll_cdr_tb.sv
module dpll_cdr_tb;
  logic clk = 0, rst_n = 0;
  logic din_man = 0, gen_en = 0, gen_din = 0;
  int gen_per = 16, gcnt = 0;
  logic [23:0] nom_inc = 24'h200000;
  logic [2:0] kp_code = 0, ki_code = 7, kg_code = 3, div_code = 0;
  logic [1:0] clamp_code = 0, quiet_code = 0;
  logic free_run = 1, mid_sample = 1, man_rst_en = 0, man_rst = 0;
  logic rec_clk, rec_data, locked;
  wire din = gen_en ? gen_din : din_man;
  int cyc = 0, nvec = 0, nfail = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk)
    if (gen_en) begin
      if (gcnt >= gen_per - 1) begin gen_din <= ~gen_din; gcnt <= 0; end
      else gcnt <= gcnt + 1;
    end

  dpll_cdr u_dut (.clk, .rst_n, .din, .nom_inc, .kp_code, .ki_code, .kg_code,
    .div_code, .clamp_code, .quiet_code, .free_run, .mid_sample, .man_rst_en,
    .man_rst, .rec_clk, .rec_data, .locked);

  task automatic chk(input string req, input bit ok, input longint act, input longint exp);
    nvec++;
    if (!ok) begin nfail++; $display("FAIL %s: actual %0d expected %0d", req, act, exp); end
  endtask

  task automatic wait_rise(output int t);
    logic p = rec_clk;
    for (int n = 0; n < 5000; n++) begin
      @(negedge clk);
      if (rec_clk && !p) break;
      p = rec_clk;
    end
    t = cyc;
  endtask

  task automatic period(output int d);
    int a, b;
    wait_rise(a); wait_rise(a); wait_rise(b);
    d = b - a;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 rec_clk", rec_clk == 1, rec_clk, 1);
    chk("R1 rec_data", rec_data == 0, rec_data, 0);
    chk("R1 locked", locked == 0, locked, 0);
  endtask

  task automatic t_freerun;
    int d;
    gen_per = 11; gen_en = 1;
    period(d); chk("R2 nominal period", d == 16, d, 16);
    chk("R2 free-run unlocked", locked == 0, locked, 0);
    div_code = 4; period(d); chk("R3 divide 20", d == 160, d, 160);
    div_code = 7; period(d); chk("R3 divide 48", d == 384, d, 384);
    div_code = 0; gen_en = 0; din_man = 0;
    period(d); chk("R2 period restored", d == 16, d, 16);
  endtask

  task automatic t_sample(input bit mid, input int exp);
    int t;
    mid_sample = mid; din_man = 0;
    wait_rise(t); wait_rise(t);
    repeat (2) @(negedge clk); din_man = 1;
    repeat (10) @(negedge clk); din_man = 0;
    wait_rise(t);
    chk(mid ? "R8 R11 mid sample" : "R8 R11 start sample", rec_data == exp, rec_data, exp);
  endtask

  task automatic t_track;
    int t0, t1, prev;
    bit ok;
    mid_sample = 1; quiet_code = 0; clamp_code = 0; gen_per = 15; gen_en = 1;
    free_run = 0;
    repeat (400) @(negedge clk);
    chk("R4 locked", locked == 1, locked, 1);
    wait_rise(t0); prev = rec_data; ok = 1;
    for (int k = 0; k < 8; k++) begin
      wait_rise(t0);
      if (rec_data == prev) ok = 0;
      prev = rec_data;
    end
    chk("R9 retimed toggles", ok, ok, 1);
    wait_rise(t0);
    for (int k = 0; k < 64; k++) wait_rise(t1);
    chk("R5 R6 clamp 1/8 tracks fast data", (t1 - t0) < 990, t1 - t0, 990);
    clamp_code = 3;
    repeat (200) @(negedge clk);
    wait_rise(t0);
    for (int k = 0; k < 64; k++) wait_rise(t1);
    chk("R6 clamp 1/64 bounds period", (t1 - t0) >= 1000, t1 - t0, 1000);
    clamp_code = 0;
  endtask

  task automatic stop_at_edge;
    logic old = gen_din;
    for (int n = 0; n < 100; n++) begin
      @(negedge clk);
      if (gen_din != old) break;
    end
    din_man = gen_din; gen_en = 0;
  endtask

  task automatic t_quiet;
    gen_per = 16; quiet_code = 1; gen_en = 1;
    repeat (200) @(negedge clk);
    chk("R7 locked before quiet", locked == 1, locked, 1);
    stop_at_edge();
    repeat (12) @(negedge clk); chk("R7 still locked after 1 bit", locked == 1, locked, 1);
    repeat (28) @(negedge clk); chk("R7 drop after 2 bits", locked == 0, locked, 0);
    gen_din = din_man; gen_en = 1;
    repeat (40) @(negedge clk); chk("R7 re-acquire", locked == 1, locked, 1);
    quiet_code = 3;
    stop_at_edge();
    repeat (100) @(negedge clk); chk("R7 still locked at 6 bits", locked == 1, locked, 1);
    repeat (50) @(negedge clk); chk("R7 drop after 8 bits", locked == 0, locked, 0);
    gen_din = din_man; gen_en = 1;
    repeat (40) @(negedge clk);
    quiet_code = 0;
    stop_at_edge();
    repeat (300) @(negedge clk); chk("R7 disabled keeps lock", locked == 1, locked, 1);
  endtask

  task automatic t_manual;
    din_man = 1;
    repeat (80) @(negedge clk);
    chk("R8 steady high", rec_data == 1, rec_data, 1);
    man_rst_en = 0; man_rst = 1; @(negedge clk); man_rst = 0; @(negedge clk);
    chk("R10 ignored locked", locked == 1, locked, 1);
    chk("R10 ignored data", rec_data == 1, rec_data, 1);
    man_rst_en = 1; man_rst = 1; @(negedge clk); man_rst = 0; @(negedge clk);
    chk("R10 cleared locked", locked == 0, locked, 0);
    chk("R10 cleared data", rec_data == 0, rec_data, 0);
    man_rst_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_freerun();
    t_sample(1, 1);
    t_sample(0, 0);
    t_track();
    t_quiet();
    t_manual();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; nvec++; nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule